// File: doc/BRIEF.md
# Redundant Sign Bit Counter

This unit measures how many bits directly below the most significant bit of a 32-bit signed fixed-point operand are copies of that bit. That number is the left shift that normalizes the value. For a non-negative operand it is the number of leading zeros minus one. For a negative operand it is the number of leading ones minus one. The result is zero-extended to a 16-bit count, and N, Z and V flags are formed from it.

A caller presents an operand with a valid strobe. One clock later the count, the flags and an output-valid strobe appear together. The unit can also produce the normalized operand, which is the input shifted left by the count with zeros entering at the bottom. A parameter removes that output. Only the 32-bit main word is supplied: any accumulator extension bits stay with the caller and never reach the unit. No saturation setting affects the result.

Top module: `rsb_counter`

## Requirements
- R1: When operand bit 31 is 0, `count` equals the number of leading zero bits of the operand minus one.
- R2: When operand bit 31 is 1, `count` equals the number of leading one bits of the operand minus one.
- R3: An operand of all zeros or all ones gives `count` = 31.
- R4: `count` is zero-extended to 16 bits, so bits 15 down to 5 are always 0.
- R5: `flagN` equals bit 15 of `count`.
- R6: `flagZ` is 1 exactly when `count` is 0.
- R7: `flagV` is always 0.
- R8: `outValid` is high in the cycle after each cycle in which `inValid` is high, and low otherwise. `count`, `normOut` and the flags for that operand are valid in the same cycle. Back-to-back operands produce back-to-back results.
- R9: While `inValid` is low, `count`, `normOut` and the flags hold their last values, whatever `operand` does.
- R10: `normOut` equals the operand shifted left by `count`, with zeros entering at bit 0. Unless `count` is 31, bits 31 and 30 of `normOut` differ.
- R11: Operand 0xD7B2_4836 gives `count` = 0x0001 and `normOut` = 0xAF64_906C.
- R12: After reset, `outValid`, `count`, `normOut` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operand strobe |
| operand | input | 32 | Main 32-bit word to examine |
| outValid | output | 1 | Result strobe, one cycle after `inValid` |
| count | output | 16 | Redundant sign bit count, zero-extended |
| normOut | output | 32 | Operand shifted left by `count` |
| flagN | output | 1 | Negative flag (bit 15 of `count`) |
| flagZ | output | 1 | Zero-result flag |
| flagV | output | 1 | Overflow flag, always cleared |

## Verification
Random operands almost never hold long runs of identical top bits. Counts in the high twenties and thirties, and the two all-equal operands, are therefore out of reach of random stimulus. The bench walks a single transition through every bit position, for both signs, so that every count from 0 to 31 appears. It then adds the all-zeros and all-ones operands and the worked example, and mixes these with seeded random operands. Hold behaviour is reached by changing `operand` while `inValid` is low and confirming that the outputs do not move.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic load;     // capture a new result this cycle
  } rsbCtl_t;

endpackage

// File: rtl/rsb_ctrl.sv
module rsb_ctrl
  import rsb_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  output rsbCtl_t ctl,
  output logic    outValid
);

  always_comb begin
    ctl      = '0;
    ctl.load = inValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

endmodule

// File: rtl/rsb_datapath.sv
module rsb_datapath
  import rsb_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int RES_W   = 16,
  parameter bit NORM_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  rsbCtl_t           ctl,
  input  logic [DATA_W-1:0] operand,
  output logic [RES_W-1:0]  count,
  output logic [DATA_W-1:0] normOut,
  output logic              flagN,
  output logic              flagZ,
  output logic              flagV
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam int TAIL_W = DATA_W - 1;

  logic [TAIL_W-1:0] diffBits;
  logic [CNT_W-1:0]  lead;
  logic [RES_W-1:0]  resNext;
  logic              found;

  // Bits that differ from the sign bit become ones; the count is the
  // number of zeros above the highest such one.
  always_comb begin
    diffBits = operand[TAIL_W-1:0] ^ {TAIL_W{operand[DATA_W-1]}};
    lead     = CNT_W'(TAIL_W);
    found    = 1'b0;
    for (int i = TAIL_W - 1; i >= 0; i--) begin
      if (!found && diffBits[i]) begin
        lead  = CNT_W'(TAIL_W - 1 - i);
        found = 1'b1;
      end
    end
    resNext = RES_W'(lead);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
      flagN <= 1'b0;
      flagZ <= 1'b0;
      flagV <= 1'b0;
    end else if (ctl.load) begin
      count <= resNext;
      flagN <= resNext[RES_W-1];
      flagZ <= (resNext == '0);
      flagV <= 1'b0;
    end
  end

  generate
    if (NORM_EN) begin : g_norm
      logic [DATA_W-1:0] normReg;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)         normReg <= '0;
        else if (ctl.load) normReg <= operand << lead;
      end
      assign normOut = normReg;
    end else begin : g_noNorm
      assign normOut = '0;
    end
  endgenerate

endmodule

// File: rtl/rsb_counter.sv
module rsb_counter
  import rsb_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int RES_W   = 16,
  parameter bit NORM_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] operand,
  output logic              outValid,
  output logic [RES_W-1:0]  count,
  output logic [DATA_W-1:0] normOut,
  output logic              flagN,
  output logic              flagZ,
  output logic              flagV
);

  rsbCtl_t ctl;

  rsb_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .ctl      (ctl),
    .outValid (outValid)
  );

  rsb_datapath #(
    .DATA_W  (DATA_W),
    .RES_W   (RES_W),
    .NORM_EN (NORM_EN)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .operand (operand),
    .count   (count),
    .normOut (normOut),
    .flagN   (flagN),
    .flagZ   (flagZ),
    .flagV   (flagV)
  );

endmodule

// File: rtl/rsb_counter_chk.sv
module rsb_counter_chk #(
  parameter int DATA_W  = 32,
  parameter int RES_W   = 16,
  parameter bit NORM_EN = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [DATA_W-1:0] operand,
  input logic              outValid,
  input logic [RES_W-1:0]  count,
  input logic [DATA_W-1:0] normOut,
  input logic              flagN,
  input logic              flagZ,
  input logic              flagV
);

  localparam int MAX_CNT = DATA_W - 1;

  // R8
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  // R9
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(count) && $stable(normOut) && $stable(flagZ) && $stable(flagN)));

  // R3 / R4
  a_r4_count_range: assert property (@(posedge clk) disable iff (!rstN)
    count <= RES_W'(MAX_CNT));

  // R5
  a_r5_n_flag: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (flagN == count[RES_W-1]));

  // R6
  a_r6_z_flag: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (flagZ == (count == '0)));

  // R7
  a_r7_v_clear: assert property (@(posedge clk) disable iff (!rstN)
    !flagV);

  // R10
  generate
    if (NORM_EN) begin : g_normChk
      a_r10_normalized: assert property (@(posedge clk) disable iff (!rstN)
        (outValid && count != RES_W'(MAX_CNT)) |-> (normOut[DATA_W-1] != normOut[DATA_W-2]));
    end
  endgenerate

endmodule

bind rsb_counter rsb_counter_chk #(
  .DATA_W  (DATA_W),
  .RES_W   (RES_W),
  .NORM_EN (NORM_EN)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .operand  (operand),
  .outValid (outValid),
  .count    (count),
  .normOut  (normOut),
  .flagN    (flagN),
  .flagZ    (flagZ),
  .flagV    (flagV)
);

// File: tb/sim_rsb_counter.sv
`timescale 1ns/1ps
module sim_rsb_counter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] operand = '0;
  logic        outValid;
  logic [15:0] count;
  logic [31:0] normOut;
  logic        flagN, flagZ, flagV;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rsb_counter u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .operand(operand),
    .outValid(outValid), .count(count), .normOut(normOut),
    .flagN(flagN), .flagZ(flagZ), .flagV(flagV)
  );

  function automatic int refCount(input logic [31:0] v);
    int n = 0;
    for (int i = 30; i >= 0; i--) begin
      if (v[i] != v[31]) break;
      n++;
    end
    return n;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Checks every output for operand v, sampled after the registering edge
  task automatic checkResult(input logic [31:0] v);
    int c = refCount(v);
    logic [15:0] expCnt = 16'(c);
    check(v[31] ? "R2 count" : "R1 count", {16'h0, count}, {16'h0, expCnt});
    check("R4 upper zero", {21'h0, count[15:5]}, 32'h0);
    check("R5 flagN", {31'h0, flagN}, {31'h0, expCnt[15]});
    check("R6 flagZ", {31'h0, flagZ}, {31'h0, (c == 0)});
    check("R7 flagV", {31'h0, flagV}, 32'h0);
    check("R10 normOut", normOut, v << c);
    check("R8 outValid", {31'h0, outValid}, 32'h1);
  endtask

  task automatic applyOne(input logic [31:0] v);
    @(negedge clk);
    inValid = 1'b1;
    operand = v;
    @(negedge clk);
    inValid = 1'b0;
    operand = $urandom;
    checkResult(v);
  endtask

  initial begin
    logic [31:0] hv;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 outValid", {31'h0, outValid}, 32'h0);
    check("R12 count", {16'h0, count}, 32'h0);
    check("R12 normOut", normOut, 32'h0);
    check("R12 flags", {29'h0, flagN, flagZ, flagV}, 32'h0);
    rstN = 1'b1;

    // R11 worked example
    applyOne(32'hD7B2_4836);
    check("R11 count", {16'h0, count}, 32'h1);
    check("R11 normOut", normOut, 32'hAF64_906C);

    // R3 all-equal operands
    applyOne(32'h0000_0000);
    check("R3 zeros", {16'h0, count}, 32'd31);
    applyOne(32'hFFFF_FFFF);
    check("R3 ones", {16'h0, count}, 32'd31);

    // R1/R2 single transition at every position
    for (int k = 0; k < 31; k++) begin
      applyOne(32'h1 << k);
      applyOne(~(32'h1 << k));
    end
    applyOne(32'h8000_0000);
    applyOne(32'h7FFF_FFFF);

    // R9 hold: operand wanders while inValid low
    applyOne(32'h0003_0000);
    hv = normOut;
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      operand = $urandom;
    end
    @(negedge clk);
    check("R9 hold count", {16'h0, count}, 32'd13);
    check("R9 hold norm", normOut, hv);
    check("R8 outValid low", {31'h0, outValid}, 32'h0);

    // R8 back-to-back
    @(negedge clk);
    inValid = 1'b1; operand = 32'h00FF_0000;
    @(negedge clk);
    operand = 32'hFFF0_1234;
    checkResult(32'h00FF_0000);
    @(negedge clk);
    inValid = 1'b0;
    checkResult(32'hFFF0_1234);

    // Random operands, some with forced long sign runs
    for (int r = 0; r < 300; r++) begin
      logic [31:0] v = $urandom;
      if (r % 3 == 0) v = $signed(v) >>> ($urandom % 32);
      applyOne(v);
    end
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule